// File: doc/BRIEF.md
# Interrupt Pending and Masking Unit

This block holds the pending state of a processor's interrupt levels and decides, every cycle, whether the core should take an interrupt. Interrupt sources raise or drop their own level through a post command or a clear command that carries a level number. A clear-all command empties the whole field at once. An on-core timer is watched too: when its compare value equals its running count, and that count is not zero, the level named by a programmable timer index becomes pending.

The take-interrupt request combines the pending field with the status flags supplied by the core. The request is allowed only while the global enable is set and neither the error-level flag nor the exception-level flag is set. It then fires when the status mask is nonzero and the pending field is nonzero. These are two separate whole-field tests; the mask and the pending field are not ANDed bit by bit. A post or clear that names a level outside the implemented range is rejected, and an error pulse reports it.

Top module: `irq_pend_unit`

## Requirements
- R1: After reset the pending field is zero, so `any_pend`, `irq_take` and `cmd_err` are all 0.
- R2: A post (`post_vld`=1) with an in-range level n (0..7) sets pending bit n at the next clock edge and leaves every other bit unchanged.
- R3: A clear (`clr_vld`=1) with an in-range level n clears pending bit n at the next clock edge and leaves every other bit unchanged.
- R4: A clear-all (`clr_all`=1) makes the whole pending field zero at the next clock edge.
- R5: A post or clear whose 4-bit level is 8..15 leaves the pending field unchanged. `cmd_err` is then 1 for exactly the cycle after that command, and 0 after any cycle without such a command.
- R6: `irq_take` is 0 whenever `glb_en` is 0, `err_lvl` is 1 or `exc_lvl` is 1, whatever the pending field and the mask hold.
- R7: With `glb_en`=1, `err_lvl`=0 and `exc_lvl`=0, `irq_take` is 1 exactly when `irq_mask` is nonzero and the pending field is nonzero. This holds even when no mask bit lines up with a pending bit.
- R8: When `tmr_cmp` equals `tmr_count` and `tmr_count` is nonzero, the pending bit whose number is the 3-bit `tmr_idx` is set at the next clock edge.
- R9: When `tmr_count` is zero, an equal `tmr_cmp` sets no pending bit.
- R10: `any_pend` is 1 exactly when the registered pending field is nonzero. The field already includes any timer update taken at the last clock edge.
- R11: When commands meet in one cycle, clear-all beats everything. A clear of bit n beats a post or a timer set of bit n. A post and a timer set combine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| post_vld | input | 1 | Post command valid |
| post_lvl | input | 4 | Level to post |
| clr_vld | input | 1 | Clear command valid |
| clr_lvl | input | 4 | Level to clear |
| clr_all | input | 1 | Clear every pending level |
| tmr_count | input | 32 | Running timer count |
| tmr_cmp | input | 32 | Timer compare value |
| tmr_idx | input | 3 | Pending level set on a timer match |
| glb_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error-level flag, blocks interrupts when 1 |
| exc_lvl | input | 1 | Exception-level flag, blocks interrupts when 1 |
| irq_mask | input | 8 | Interrupt mask from the status register |
| irq_take | output | 1 | Core should take an interrupt |
| any_pend | output | 1 | At least one level is pending |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range post or clear |

## Verification
Single posts and clears are applied over every level. This separates the correct bit from a neighbour and shows that the other bits are kept. The gating inputs are swept through all eight flag combinations while state is pending. A mask with no bit in common with the pending bits separates the whole-field test from a bitwise AND. Timer patterns set equal compare and count at zero and at nonzero values for each index. Same-cycle collisions of clear-all, clear, post and timer set fix the priority order. A long random mix, with level values that cross the valid range, checks the error pulse and the unchanged field against the model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Number of bits needed to name one of n items (at least 1).
   function automatic int idx_bits(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   typedef enum logic [1:0] {
      PRIO_NONE  = 2'd0,
      PRIO_SET   = 2'd1,
      PRIO_CLR   = 2'd2,
      PRIO_FLUSH = 2'd3
   } prio_e;

endpackage

// File: rtl/irq_lvl_decode.sv
module irq_lvl_decode #(
   parameter int NUM_LEVELS = 8,
   parameter int LVL_W      = 4
) (
   input  logic                  cmd_vld,
   input  logic [LVL_W-1:0]      cmd_lvl,
   output logic [NUM_LEVELS-1:0] hit,
   output logic                  bad
);
   localparam bit HAS_OOR = ((1 << LVL_W) > NUM_LEVELS);

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_hit
      assign hit[i] = cmd_vld && (cmd_lvl == LVL_W'(i));
   end

   if (HAS_OOR) begin : g_oor
      assign bad = cmd_vld && (cmd_lvl >= LVL_W'(NUM_LEVELS));
   end else begin : g_no_oor
      assign bad = 1'b0;
   end
endmodule

// File: rtl/irq_tmr_match.sv
module irq_tmr_match #(
   parameter int NUM_LEVELS = 8,
   parameter int CNT_W      = 32,
   parameter int IDX_W      = 3
) (
   input  logic [CNT_W-1:0]      count,
   input  logic [CNT_W-1:0]      cmp,
   input  logic [IDX_W-1:0]      idx,
   output logic [NUM_LEVELS-1:0] set
);
   logic match;

   assign match = (count == cmp) && (|count);

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_sel
      assign set[i] = match && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_LEVELS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] set_bits,
   input  logic [NUM_LEVELS-1:0] clr_bits,
   input  logic                  flush,
   output logic [NUM_LEVELS-1:0] pend
);
   import irq_pkg::*;

   logic [NUM_LEVELS-1:0] pend_d;

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_bit
      prio_e sel;
      always_comb begin
         if (flush)            sel = PRIO_FLUSH;
         else if (clr_bits[i]) sel = PRIO_CLR;
         else if (set_bits[i]) sel = PRIO_SET;
         else                  sel = PRIO_NONE;
      end
      always_comb begin
         case (sel)
            PRIO_FLUSH: pend_d[i] = 1'b0;
            PRIO_CLR:   pend_d[i] = 1'b0;
            PRIO_SET:   pend_d[i] = 1'b1;
            default:    pend_d[i] = pend[i];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_d;
   end
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate #(
   parameter int NUM_LEVELS = 8
) (
   input  logic                  glb_en,
   input  logic                  err_lvl,
   input  logic                  exc_lvl,
   input  logic [NUM_LEVELS-1:0] mask,
   input  logic [NUM_LEVELS-1:0] pend,
   output logic                  take,
   output logic                  any
);
   logic allowed;

   assign any     = |pend;
   assign allowed = glb_en && !err_lvl && !exc_lvl;
   assign take    = allowed && (|mask) && any;
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
   parameter int NUM_LEVELS = 8,
   parameter int LVL_W      = 4,
   parameter int CNT_W      = 32,
   parameter int IDX_W      = irq_pkg::idx_bits(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  post_vld,
   input  logic [LVL_W-1:0]      post_lvl,
   input  logic                  clr_vld,
   input  logic [LVL_W-1:0]      clr_lvl,
   input  logic                  clr_all,
   input  logic [CNT_W-1:0]      tmr_count,
   input  logic [CNT_W-1:0]      tmr_cmp,
   input  logic [IDX_W-1:0]      tmr_idx,
   input  logic                  glb_en,
   input  logic                  err_lvl,
   input  logic                  exc_lvl,
   input  logic [NUM_LEVELS-1:0] irq_mask,
   output logic                  irq_take,
   output logic                  any_pend,
   output logic                  cmd_err
);
   if (NUM_LEVELS < 2) begin : g_chk_levels
      $error("irq_pend_unit: NUM_LEVELS must be at least 2");
   end
   if ((1 << LVL_W) < NUM_LEVELS) begin : g_chk_lvl_w
      $error("irq_pend_unit: LVL_W too narrow for NUM_LEVELS");
   end
   if ((1 << IDX_W) < NUM_LEVELS) begin : g_chk_idx_w
      $error("irq_pend_unit: IDX_W too narrow for NUM_LEVELS");
   end
   if (CNT_W < 1) begin : g_chk_cnt_w
      $error("irq_pend_unit: CNT_W must be positive");
   end

   logic [NUM_LEVELS-1:0] post_hit, clr_hit, tmr_set, pend_q;
   logic                  post_bad, clr_bad;

   irq_lvl_decode #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_post_dec (
      .cmd_vld (post_vld),
      .cmd_lvl (post_lvl),
      .hit     (post_hit),
      .bad     (post_bad)
   );

   irq_lvl_decode #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_clr_dec (
      .cmd_vld (clr_vld),
      .cmd_lvl (clr_lvl),
      .hit     (clr_hit),
      .bad     (clr_bad)
   );

   irq_tmr_match #(.NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tmr (
      .count (tmr_count),
      .cmp   (tmr_cmp),
      .idx   (tmr_idx),
      .set   (tmr_set)
   );

   irq_pend_reg #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (post_hit | tmr_set),
      .clr_bits (clr_hit),
      .flush    (clr_all),
      .pend     (pend_q)
   );

   irq_take_gate #(.NUM_LEVELS(NUM_LEVELS)) u_gate (
      .glb_en  (glb_en),
      .err_lvl (err_lvl),
      .exc_lvl (exc_lvl),
      .mask    (irq_mask),
      .pend    (pend_q),
      .take    (irq_take),
      .any     (any_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_err <= 1'b0;
      else        cmd_err <= post_bad || clr_bad;
   end
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
   parameter int NUM_LEVELS = 8,
   parameter int LVL_W      = 4,
   parameter int CNT_W      = 32,
   parameter int IDX_W      = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  post_vld,
   input logic [LVL_W-1:0]      post_lvl,
   input logic                  clr_vld,
   input logic [LVL_W-1:0]      clr_lvl,
   input logic                  clr_all,
   input logic [CNT_W-1:0]      tmr_count,
   input logic [CNT_W-1:0]      tmr_cmp,
   input logic                  glb_en,
   input logic                  err_lvl,
   input logic                  exc_lvl,
   input logic [NUM_LEVELS-1:0] irq_mask,
   input logic [NUM_LEVELS-1:0] pend_q,
   input logic                  irq_take,
   input logic                  any_pend,
   input logic                  cmd_err
);
   logic post_ok, clr_ok, bad_cmd, quiet;

   assign post_ok = post_vld && ({1'b0, post_lvl} < (LVL_W+1)'(NUM_LEVELS));
   assign clr_ok  = clr_vld  && ({1'b0, clr_lvl}  < (LVL_W+1)'(NUM_LEVELS));
   assign bad_cmd = (post_vld && !post_ok) || (clr_vld && !clr_ok);
   assign quiet   = !post_ok && !clr_ok && !clr_all;

   // R2: an uncontested in-range post shows up in the field
   assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (post_ok && !clr_vld && !clr_all) |=> pend_q[$past(post_lvl)]);

   // R3: an in-range clear drops its bit
   assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |=> !pend_q[$past(clr_lvl)]);

   // R4, R11: clear-all empties the field whatever else arrives
   assert_flush_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (pend_q == '0) && !any_pend);

   // R5: error pulse follows exactly the bad commands
   assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |=> cmd_err);
   assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_cmd |=> !cmd_err);

   // R5, R9: no valid command and a zero count leave the field alone
   assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && (tmr_count == '0)) |=> $stable(pend_q));

   // R6: blocked core never gets a request
   assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en || err_lvl || exc_lvl) |-> !irq_take);

   // R7: open gate, nonzero mask and something pending give a request
   assert_take_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && !err_lvl && !exc_lvl && (|irq_mask) && any_pend) |-> irq_take);
endmodule

bind irq_pend_unit irq_pend_chk #(
   .NUM_LEVELS (NUM_LEVELS),
   .LVL_W      (LVL_W),
   .CNT_W      (CNT_W),
   .IDX_W      (IDX_W)
) u_irq_pend_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .post_vld  (post_vld),
   .post_lvl  (post_lvl),
   .clr_vld   (clr_vld),
   .clr_lvl   (clr_lvl),
   .clr_all   (clr_all),
   .tmr_count (tmr_count),
   .tmr_cmp   (tmr_cmp),
   .glb_en    (glb_en),
   .err_lvl   (err_lvl),
   .exc_lvl   (exc_lvl),
   .irq_mask  (irq_mask),
   .pend_q    (pend_q),
   .irq_take  (irq_take),
   .any_pend  (any_pend),
   .cmd_err   (cmd_err)
);

// File: tb/test_irq_pend_unit.sv
module test_irq_pend_unit;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        post_vld = 0, clr_vld = 0, clr_all = 0;
   logic [3:0]  post_lvl = 0, clr_lvl = 0;
   logic [31:0] tmr_count = 0, tmr_cmp = 0;
   logic [2:0]  tmr_idx = 0;
   logic        glb_en = 0, err_lvl = 0, exc_lvl = 0;
   logic [7:0]  irq_mask = 0;
   logic        irq_take, any_pend, cmd_err;

   int unsigned n_vec = 0, n_bad = 0;
   bit          done = 0;

   // behavioural model state
   int m_pend = 0;
   int m_err  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pend_unit i_irq_pend_unit (
      .clk(clk), .rst_n(rst_n),
      .post_vld(post_vld), .post_lvl(post_lvl),
      .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_all(clr_all),
      .tmr_count(tmr_count), .tmr_cmp(tmr_cmp), .tmr_idx(tmr_idx),
      .glb_en(glb_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
      .irq_mask(irq_mask),
      .irq_take(irq_take), .any_pend(any_pend), .cmd_err(cmd_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // One clock: drive at the falling edge, compare, then advance the model.
   task automatic cyc(input bit pv, input int pl, input bit cv, input int cl, input bit ca,
                      input int cnt, input int cmp, input int idx,
                      input bit en, input bit erl, input bit exl, input int msk,
                      input string req);
      int nxt;
      bit m_take;
      @(negedge clk);
      post_vld = pv; post_lvl = pl[3:0];
      clr_vld = cv;  clr_lvl = cl[3:0];
      clr_all = ca;
      tmr_count = cnt; tmr_cmp = cmp; tmr_idx = idx[2:0];
      glb_en = en; err_lvl = erl; exc_lvl = exl; irq_mask = msk[7:0];
      #1;
      m_take = en && !erl && !exl && ((msk & 255) != 0) && (m_pend != 0);
      chk(req, "irq_take", int'(irq_take), int'(m_take));
      chk(req, "any_pend", int'(any_pend), int'(m_pend != 0));
      chk(req, "cmd_err",  int'(cmd_err),  m_err);
      nxt = m_pend;
      if (pv && (pl & 15) < N) nxt = nxt | (1 << (pl & 15));
      if (cnt == cmp && cnt != 0) nxt = nxt | (1 << (idx & 7));
      if (cv && (cl & 15) < N) nxt = nxt & ~(1 << (cl & 15));
      if (ca) nxt = 0;
      @(posedge clk);
      m_pend = nxt & 255;
      m_err  = ((pv && (pl & 15) >= N) || (cv && (cl & 15) >= N)) ? 1 : 0;
   endtask

   // idle cycle with gate open, full mask, so outputs expose state
   task automatic idle(input string req);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 255, req);
   endtask

   task automatic post(input int l, input string req);
      cyc(1, l, 0, 0, 0, 0, 0, 0, 1, 0, 0, 255, req);
   endtask

   task automatic clear(input int l, input string req);
      cyc(0, 0, 1, l, 0, 0, 0, 0, 1, 0, 0, 255, req);
   endtask

   task automatic flush(input string req);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 255, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      glb_en = 1; irq_mask = 8'hff;
      #1;
      chk("R1", "any_pend in reset", int'(any_pend), 0);
      chk("R1", "irq_take in reset", int'(irq_take), 0);
      rst_n = 1'b1;
      idle("R1");
      idle("R1");

      // R2: each level posted alone, then kept while others arrive
      for (int l = 0; l < N; l++) begin
         post(l, "R2");
         idle("R10");
         flush("R4");
      end
      for (int l = 0; l < N; l++) post(l, "R2");
      idle("R10");

      // R3: clear each level one at a time from a full field
      for (int l = N-1; l >= 0; l--) clear(l, "R3");
      idle("R10");
      post(2, "R2"); post(6, "R2");
      clear(6, "R3"); idle("R3");
      clear(2, "R3"); idle("R3");

      // R4: flush a partly filled field
      post(0, "R2"); post(5, "R2"); post(7, "R2");
      flush("R4"); idle("R4");

      // R5: out-of-range post and clear
      post(3, "R2");
      for (int l = N; l < 16; l++) begin
         post(l, "R5");
         idle("R5");
         clear(l, "R5");
         idle("R5");
      end
      cyc(1, 9, 1, 12, 0, 0, 0, 0, 1, 0, 0, 255, "R5");
      idle("R5"); idle("R5");

      // R6: gating combinations with bit 3 pending
      for (int g = 0; g < 8; g++)
         cyc(0, 0, 0, 0, 0, 0, 0, 0, g[0], g[1], g[2], 255, "R6");

      // R7: mask disjoint from pending, single bits, zero mask
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h01, "R7");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h80, "R7");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00, "R7");
      flush("R4");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'hff, "R7");

      // R8: timer match on every index
      for (int i = 0; i < N; i++) begin
         cyc(0, 0, 0, 0, 0, 100 + i, 100 + i, i, 1, 0, 0, 255, "R8");
         idle("R8");
         flush("R4");
      end
      cyc(0, 0, 0, 0, 0, 77, 78, 4, 1, 0, 0, 255, "R8");
      idle("R8");

      // R9: zero count with equal compare is ignored
      for (int i = 0; i < N; i++)
         cyc(0, 0, 0, 0, 0, 0, 0, i, 1, 0, 0, 255, "R9");
      idle("R9");

      // R11: collisions
      cyc(1, 4, 1, 4, 0, 0, 0, 0, 1, 0, 0, 255, "R11");
      idle("R11");
      cyc(0, 0, 1, 2, 0, 9, 9, 2, 1, 0, 0, 255, "R11");
      idle("R11");
      cyc(1, 1, 0, 0, 0, 9, 9, 6, 1, 0, 0, 255, "R11");
      idle("R11");
      cyc(1, 3, 0, 0, 1, 9, 9, 5, 1, 0, 0, 255, "R11");
      idle("R11");
      cyc(1, 3, 1, 5, 0, 9, 9, 5, 1, 0, 0, 255, "R11");
      idle("R11");

      // mixed random traffic against the model
      for (int k = 0; k < 3000; k++) begin
         int c;
         int r;
         c = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 5);
         r = $urandom_range(0, 2);
         cyc($urandom_range(0, 1), $urandom_range(0, 15),
             ($urandom_range(0, 2) == 0), $urandom_range(0, 15),
             ($urandom_range(0, 19) == 0),
             c, (r == 0) ? c : $urandom_range(0, 5), $urandom_range(0, 7),
             ($urandom_range(0, 4) != 0), ($urandom_range(0, 5) == 0),
             ($urandom_range(0, 5) == 0),
             ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 255), "R11");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule